// File: doc/BRIEF.md
# Multi-bank GPIO interrupt aggregator

This block collects edge events from up to five 32-pin GPIO register sets. Each set holds a 32-bit pending word. A pin event sets a pending bit, and software clears it by writing ones to the set's status address. The block splits every pending word into two 16-pin interrupt banks and drives one interrupt line per bank. Each line is gated by one bit of a global bank-enable register. The block also reports the number of the lowest enabled pending interrupt, so a handler can dispatch without scanning the status words.

The `DIRECT_PINS` parameter selects the mode. When it is zero the block works in banked mode. When it is nonzero the block works in direct mode, and the first `DIRECT_PINS` pins of set 0 each drive their own interrupt line. All bank lines and the number output are then held low.

The block has no state machine. Address decode uses an enumerated access kind:
- `ACC_NONE` means the address maps to nothing.
- `ACC_ENABLE` selects the bank-enable register.
- `ACC_STATUS` selects a set's pending word.

Top module: `gpio_irq_aggr`

## Requirements
- R1: The bank-enable register sits at byte address 0x08 and resets to 0. Only bits 2*NSETS-1:0 can be written, and all other bits read as 0.
- R2: The pending word of set k is read at byte address 0x10 + 0x28*k + 0x24, which gives 0x34, 0x5C, 0x84, 0xAC and 0xD4. Writing a word there clears every pending bit whose data bit is 1.
- R3: A one-cycle pulse on `pin_evt[32*k+j]` sets bit j of set k's pending word. If a clear of the same bit happens in the same cycle, the event wins.
- R4: Bank b takes set b/2. An even b uses pending bits 15:0 and an odd b uses bits 31:16. `bank_irq[b]` is the OR of those 16 bits ANDed with enable bit b. It is registered, so it appears one cycle after the pending word or the enable register changes.
- R5: A bank line stays high while any of its 16 bits is pending, and it falls only after the last of them has been cleared.
- R6: In banked mode, `irq_num` carries the lowest value of (b/2)*32 + bit position over all pending bits whose bank is enabled. `irq_num_vld` is high when such a bit exists. Both are registered and appear with the same latency as `bank_irq`.
- R7: Reads of any address other than those in R1 and R2 return 0. This includes the status address of an absent set. Writes to such addresses change neither the enable register nor any pending word.
- R8: `bank_irq` bits for banks 2*NSETS and above stay low.
- R9: In direct mode, `direct_irq[i]` for i < DIRECT_PINS equals set 0 pending bit i ANDed with enable bit i/16, registered one cycle. In this mode `bank_irq`, `irq_num_vld` and `direct_irq` bits at or above DIRECT_PINS stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data, 0 when no read is active |
| pin_evt | input | NSETS*32 | One-cycle pin event pulses, 32 per set |
| bank_irq | output | 10 | One interrupt line per 16-pin bank |
| direct_irq | output | 32 | Per-pin interrupt lines in direct mode |
| irq_num | output | 8 | Lowest enabled pending interrupt number |
| irq_num_vld | output | 1 | `irq_num` is meaningful |

## Verification
Two cases are hard to reach from the ports. The first is a pin event and a write-one-to-clear of the same bit landing in one clock. The bench reaches it by driving the event pulse and the status write from the same task step, so both hit one edge, and then reading the word back. The second is a bank holding two pending bits while software clears only one. The bench sets two bits in one bank and clears them in separate writes, checking the bank line and the reported number after each write.

// File: rtl/gpio_aggr_pkg.sv
package gpio_aggr_pkg;
    localparam int SET_MAX    = 5;
    localparam int SET_PINS   = 32;
    localparam int BANK_PINS  = 16;
    localparam int BANK_MAX   = SET_MAX * 2;
    localparam int NUM_W      = 8;
    localparam int EN_ADDR    = 'h08;
    localparam int SET0_BASE  = 'h10;
    localparam int SET_STRIDE = 'h28;
    localparam int STAT_OFS   = 'h24;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ENABLE,
        ACC_STATUS
    } acc_kind_e;
endpackage

// File: rtl/gpio_pend_set.sv
module gpio_pend_set #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_stb_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] pend_q;
    logic [W-1:0] clr_eff;

    always_comb clr_eff = clr_stb_i ? clr_mask_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_eff) | evt_i;
    end

    assign pend_o = pend_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stb_i |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R5
    AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i))); // R3
endmodule

// File: rtl/gpio_bank_gate.sv
module gpio_bank_gate #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bits_i,
    input  logic         en_i,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= en_i & (|bits_i);
    end

    assign irq_o = irq_q;

    AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_i)); // R4
    AST_GATE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|bits_i)); // R5
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
    parameter int N     = 160,
    parameter int NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    output logic [NUM_W-1:0] num_o,
    output logic             vld_o
);
    logic [NUM_W-1:0] num_d;
    logic             vld_d;
    logic [NUM_W-1:0] num_q;
    logic             vld_q;

    always_comb begin
        num_d = '0;
        vld_d = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                num_d = NUM_W'(i);
                vld_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q <= '0;
            vld_q <= 1'b0;
        end else begin
            num_q <= num_d;
            vld_q <= vld_d;
        end
    end

    assign num_o = num_q;
    assign vld_o = vld_q;

    AST_NUM_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $past(|req_i)); // R6
endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr
    import gpio_aggr_pkg::*;
#(
    parameter int NSETS       = 5,
    parameter int DIRECT_PINS = 0,
    parameter int ADDR_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_rd,
    output logic [31:0]           bus_rdata,
    input  logic [NSETS*32-1:0]   pin_evt,
    output logic [BANK_MAX-1:0]   bank_irq,
    output logic [31:0]           direct_irq,
    output logic [NUM_W-1:0]      irq_num,
    output logic                  irq_num_vld
);
    localparam bit               BANKED    = (DIRECT_PINS == 0);
    localparam int               LIVE_BANKS = 2 * NSETS;
    localparam logic [BANK_MAX-1:0] LIVE_MASK =
        BANK_MAX'((1 << LIVE_BANKS) - 1);
    localparam int               FLAT_W    = SET_MAX * SET_PINS;

    acc_kind_e          acc_kind;
    logic [2:0]         acc_set;
    logic [BANK_MAX-1:0] en_q;
    logic [FLAT_W-1:0]  pend_all;
    logic [FLAT_W-1:0]  prio_req;

    // address decode
    always_comb begin
        acc_kind = ACC_NONE;
        acc_set  = '0;
        if (32'(bus_addr) == EN_ADDR) acc_kind = ACC_ENABLE;
        for (int k = 0; k < NSETS; k++) begin
            if (32'(bus_addr) == SET0_BASE + k * SET_STRIDE + STAT_OFS) begin
                acc_kind = ACC_STATUS;
                acc_set  = 3'(k);
            end
        end
    end

    // bank-enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else if (bus_wr && acc_kind == ACC_ENABLE)
            en_q <= bus_wdata[BANK_MAX-1:0] & LIVE_MASK;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (acc_kind)
                ACC_ENABLE: bus_rdata = 32'(en_q);
                ACC_STATUS: bus_rdata = pend_all[{acc_set, 5'd0} +: 32];
                default:    bus_rdata = '0;
            endcase
        end
    end

    // pending register sets
    for (genvar k = 0; k < SET_MAX; k++) begin : g_set
        if (k < NSETS) begin : g_live
            logic clr_stb;
            assign clr_stb = bus_wr && (acc_kind == ACC_STATUS) && (acc_set == 3'(k));
            gpio_pend_set #(.W(SET_PINS)) set_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt_i     (pin_evt[k*SET_PINS +: SET_PINS]),
                .clr_stb_i (clr_stb),
                .clr_mask_i(bus_wdata),
                .pend_o    (pend_all[k*SET_PINS +: SET_PINS])
            );
        end else begin : g_absent
            assign pend_all[k*SET_PINS +: SET_PINS] = '0;
        end
    end

    // bank lines and priority request vector
    for (genvar b = 0; b < BANK_MAX; b++) begin : g_bank
        if (BANKED && b < LIVE_BANKS) begin : g_gate
            gpio_bank_gate #(.W(BANK_PINS)) gate_i (
                .clk   (clk),
                .rst_n (rst_n),
                .bits_i(pend_all[b*BANK_PINS +: BANK_PINS]),
                .en_i  (en_q[b]),
                .irq_o (bank_irq[b])
            );
            assign prio_req[b*BANK_PINS +: BANK_PINS] =
                pend_all[b*BANK_PINS +: BANK_PINS] & {BANK_PINS{en_q[b]}};
        end else begin : g_tie
            assign bank_irq[b] = 1'b0;
            assign prio_req[b*BANK_PINS +: BANK_PINS] = '0;
        end
    end

    gpio_irq_prio #(.N(FLAT_W), .NUM_W(NUM_W)) prio_i (
        .clk  (clk),
        .rst_n(rst_n),
        .req_i(prio_req),
        .num_o(irq_num),
        .vld_o(irq_num_vld)
    );

    // direct per-pin lines
    for (genvar i = 0; i < 32; i++) begin : g_dir
        if (!BANKED && i < DIRECT_PINS) begin : g_pin
            logic dq;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dq <= 1'b0;
                else        dq <= pend_all[i] & en_q[i/BANK_PINS];
            end
            assign direct_irq[i] = dq;
            AST_DIRECT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
                dq |-> $past(en_q[i/BANK_PINS])); // R9
        end else begin : g_off
            assign direct_irq[i] = 1'b0;
        end
    end

    AST_NUM_HAS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_num_vld |-> $past(|en_q)); // R6
    AST_DEAD_BANKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_irq & ~LIVE_MASK) == '0); // R8
    AST_EN_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && acc_kind == ACC_NONE) |=> $stable(en_q)); // R7
endmodule

// File: tb/gpio_irq_aggr_tb.sv
module gpio_irq_aggr_tb_top;
    localparam int K_WR = 0, K_RD = 1, K_EVT = 2, K_IDLE = 3, K_IRQ = 4, K_NUM = 5;
    localparam int NV = 32;
    // {req[3:0], kind[2:0], addr[7:0], data[31:0]}
    localparam logic [46:0] VEC [NV] = '{
        {4'd1, 3'd1, 8'h08, 32'h0000_0000},  // R1 reset value
        {4'd3, 3'd2, 8'd0,  32'h0001_0002},  // R3 set0 bits 1,16
        {4'd0, 3'd3, 8'h00, 32'h0},
        {4'd4, 3'd4, 8'h00, 32'h0000_0000},  // R4 all gated off
        {4'd2, 3'd1, 8'h34, 32'h0001_0002},  // R2 read set0
        {4'd1, 3'd0, 8'h08, 32'hFFFF_FFFF},
        {4'd1, 3'd1, 8'h08, 32'h0000_00FF},  // R1 only live bits
        {4'd4, 3'd4, 8'h00, 32'h0000_0003},  // R4 banks 0,1
        {4'd6, 3'd5, 8'h00, 32'h0000_0101},  // R6 num 1
        {4'd2, 3'd0, 8'h34, 32'h0000_0002},
        {4'd0, 3'd3, 8'h00, 32'h0},
        {4'd5, 3'd4, 8'h00, 32'h0000_0002},  // R5 bank0 dropped
        {4'd6, 3'd5, 8'h00, 32'h0000_0110},  // R6 num 16
        {4'd3, 3'd2, 8'd3,  32'h8000_0000},
        {4'd3, 3'd2, 8'd2,  32'h0000_0100},
        {4'd0, 3'd3, 8'h00, 32'h0},
        {4'd4, 3'd4, 8'h00, 32'h0000_0092},  // R4 odd/even split
        {4'd6, 3'd5, 8'h00, 32'h0000_0110},  // R6 lowest wins
        {4'd2, 3'd0, 8'h34, 32'h0001_0000},
        {4'd0, 3'd3, 8'h00, 32'h0},
        {4'd6, 3'd5, 8'h00, 32'h0000_0148},  // R6 num 72
        {4'd1, 3'd0, 8'h08, 32'h0000_0080},
        {4'd0, 3'd3, 8'h00, 32'h0},
        {4'd4, 3'd4, 8'h00, 32'h0000_0080},  // R4 only bank7
        {4'd6, 3'd5, 8'h00, 32'h0000_017F},  // R6 num 127
        {4'd7, 3'd0, 8'hD4, 32'hFFFF_FFFF},  // R7 absent set
        {4'd7, 3'd0, 8'h0C, 32'h0000_0000},  // R7 hole
        {4'd7, 3'd1, 8'h08, 32'h0000_0080},  // R7 enable unchanged
        {4'd7, 3'd1, 8'hD4, 32'h0000_0000},  // R7 reads zero
        {4'd2, 3'd1, 8'hAC, 32'h8000_0000},  // R2 set3 intact
        {4'd7, 3'd1, 8'h30, 32'h0000_0000},  // R7 other offset
        {4'd8, 3'd4, 8'h00, 32'h0000_0080}   // R8 banks 8,9 low
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a_addr = '0, d_addr = '0;
    logic        a_wr = 1'b0, a_rd = 1'b0, d_wr = 1'b0, d_rd = 1'b0;
    logic [31:0] a_wdata = '0, d_wdata = '0;
    logic [31:0] a_rdata, d_rdata;
    logic [127:0] a_evt = '0;
    logic [31:0] d_evt = '0;
    logic [9:0]  a_bank, d_bank;
    logic [31:0] a_dir, d_dir;
    logic [7:0]  a_num, d_num;
    logic        a_vld, d_vld;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_aggr #(.NSETS(4), .DIRECT_PINS(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr),
        .bus_wdata(a_wdata), .bus_rd(a_rd), .bus_rdata(a_rdata),
        .pin_evt(a_evt), .bank_irq(a_bank), .direct_irq(a_dir),
        .irq_num(a_num), .irq_num_vld(a_vld));

    gpio_irq_aggr #(.NSETS(1), .DIRECT_PINS(20)) dut_d (
        .clk(clk), .rst_n(rst_n), .bus_addr(d_addr), .bus_wr(d_wr),
        .bus_wdata(d_wdata), .bus_rd(d_rd), .bus_rdata(d_rdata),
        .pin_evt(d_evt), .bank_irq(d_bank), .direct_irq(d_dir),
        .irq_num(d_num), .irq_num_vld(d_vld));

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        a_wr = 0; a_rd = 0; a_evt = '0; d_wr = 0; d_rd = 0; d_evt = '0;
    endtask

    task automatic step();
        @(negedge clk);
        quiet();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL R0 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        #1;
        // reset state, R1 R6 R9
        chk(1, 32'(a_bank), 0, "bank lines after reset");
        chk(6, 32'(a_vld), 0, "num valid after reset");
        chk(9, d_dir, 0, "direct lines after reset");

        for (int v = 0; v < NV; v++) begin
            step();
            case (int'(VEC[v][42:40]))
                K_WR:  begin a_addr = VEC[v][39:32]; a_wdata = VEC[v][31:0]; a_wr = 1; end
                K_EVT: a_evt = 128'(VEC[v][31:0]) << (32 * int'(VEC[v][39:32]));
                K_RD:  begin
                    a_addr = VEC[v][39:32]; a_rd = 1; #1;
                    chk(int'(VEC[v][46:43]), a_rdata, VEC[v][31:0], $sformatf("row %0d read", v));
                end
                K_IRQ: begin #1;
                    chk(int'(VEC[v][46:43]), 32'(a_bank), VEC[v][31:0], $sformatf("row %0d bank_irq", v));
                end
                K_NUM: begin #1;
                    chk(int'(VEC[v][46:43]), {23'd0, a_vld, a_num}, VEC[v][31:0], $sformatf("row %0d irq_num", v));
                end
                default: ;
            endcase
        end

        // R3: event and clear of the same bit in one cycle
        step(); a_evt[37] = 1; a_addr = 8'h5C; a_wdata = 32'h20; a_wr = 1;
        step(); a_addr = 8'h5C; a_rd = 1; #1;
        chk(3, a_rdata, 32'h20, "event beats clear");

        // R5, R6: two bits in bank2 cleared one at a time
        step(); a_evt[35] = 1; a_addr = 8'h08; a_wdata = 32'h84; a_wr = 1;
        step();
        step(); #1;
        chk(4, 32'(a_bank), 32'h84, "bank2 raised");
        chk(6, {23'd0, a_vld, a_num}, 32'h123, "num 35");
        step(); a_addr = 8'h5C; a_wdata = 32'h08; a_wr = 1;
        step();
        step(); #1;
        chk(5, 32'(a_bank), 32'h84, "bank2 held by bit5");
        chk(6, {23'd0, a_vld, a_num}, 32'h125, "num 37");
        step(); a_addr = 8'h5C; a_wdata = 32'h20; a_wr = 1;
        step();
        step(); #1;
        chk(5, 32'(a_bank), 32'h80, "bank2 released");
        chk(6, {23'd0, a_vld, a_num}, 32'h17F, "num 127, bank4 disabled");

        // R9: direct mode
        step(); d_evt = 32'h0208_0001; d_addr = 8'h08; d_wdata = 32'h3; d_wr = 1;
        step();
        step(); #1;
        chk(9, d_dir, 32'h0008_0001, "direct pins 0,19");
        chk(9, 32'(d_bank), 0, "bank lines low in direct mode");
        chk(9, 32'(d_vld), 0, "num invalid in direct mode");
        d_addr = 8'h34; d_rd = 1; #1;
        chk(2, d_rdata, 32'h0208_0001, "direct set0 pending");
        step(); d_addr = 8'h08; d_wdata = 32'h1; d_wr = 1;
        step();
        step(); #1;
        chk(9, d_dir, 32'h0000_0001, "upper direct group disabled");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule